// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block collects every condition that must force a PWM power stage off and turns them into one latched shutdown signal for the output stage. Three kinds of source can trip it. The first is an active-low trip pin, which forces the shutdown output at once through a combinational path that needs no clock. The second is a falling edge on any of twelve general-purpose input lines, each of which a mask register can enable or disable as a fault source. The third is a software write of any value to a trip register.

While the shutdown is in force, the block suppresses the PWM sync pulse and its interrupt request. Software reads the status register to see the synchronized trip-pin level and the state of the latch. Software reads the trip register to learn whether the most recent shutdown came from software; that read clears the flag. The latch stays set until software writes a re-enable bit at a time when no fault source is active.

Pull resistors on the pads are represented by the reset values of the synchronizers. Both the trip pin and the I/O lines are treated as pulled low, which means a disconnected pin reads as a fault.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: A low level on `trip_n` drives `shutdown` high in the same time step, with no clock edge needed.
- R2: A read of address 0 returns the two-flop synchronized `trip_n` level in bit 0 and the latch state in bit 1. All other bits read 0.
- R3: Address 1 is the 12-bit line-enable mask. Bit n enables `gpio_in[n]` as a fault source. The mask is 0x0FFF after reset, and bits 15..12 read 0.
- R4: A falling edge on an enabled `gpio_in` line sets the latch within three clock edges. An edge on a disabled line has no effect.
- R5: After reset the latch is set, so `shutdown` is 1.
- R6: A write of any data value to address 2 sets the latch on the next edge.
- R7: A write to address 2 sets a software-source flag. A read of address 2 returns that flag in bit 0 and clears it, so a second read returns 0.
- R8: A hardware trip, from the pin or from an I/O line, leaves the software-source flag unchanged.
- R9: A write to address 3 with bit 0 set clears the latch only when the synchronized `trip_n` is high and no enabled line is low. Otherwise the write has no effect.
- R10: While `shutdown` is 1, `sync_out` is 0 and `sync_irq` stays low. Otherwise `sync_out` follows `sync_in`, and `sync_irq` is a copy of `sync_in` registered one cycle later.
- R11: `reg_rdata` is registered: it carries the read result in the cycle after `reg_rd` and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trip_n | input | 1 | Active-low asynchronous trip pin |
| gpio_in | input | 12 | General-purpose lines that can act as fault sources |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| sync_in | input | 1 | Sync pulse from the PWM timer |
| sync_out | output | 1 | Gated sync pulse |
| sync_irq | output | 1 | Sync interrupt request |
| shutdown | output | 1 | PWM shutdown command |

## Verification
The assertions assume several things about the inputs. `reg_wr` and `reg_rd` are never asserted in the same cycle. A low on `trip_n` is held across any register access that the properties relate to it. `sync_in` is stable within each cycle. The bench changes every input only on the falling clock edge. It performs exactly one register access at a time. It holds each pin level for several cycles before it accesses a register, so the two-flop synchronizers have settled before any result is checked.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned NUM_LINES = 12;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_SWTRIP = 2'd2,
    ADDR_CTRL   = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_TRIP_BIT  = 0;
  localparam int unsigned STAT_LATCH_BIT = 1;
  localparam int unsigned CTRL_REEN_BIT  = 0;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] enable,
  output logic         fall_any,
  output logic         low_any
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;
  logic [N-1:0] fall_vec;
  logic [N-1:0] low_vec;

  always_comb begin
    prev_d = lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign fall_vec[i] = enable[i] & prev_q[i] & ~lines[i];
    assign low_vec[i]  = enable[i] & ~lines[i];
  end

  assign fall_any = |fall_vec;
  assign low_any  = |low_vec;
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N  = NUM_LINES,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          trip_level,
  input  logic          latch_state,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  mask,
  output logic          sw_trip,
  output logic          reen_req
);
  logic [N-1:0]  mask_q,  mask_d;
  logic          flag_q,  flag_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          mask_we, flag_set, flag_clr;
  logic [DW-1:0] status_word;
  logic [DW-1:0] mask_word;
  logic [DW-1:0] flag_word;

  assign mask_we  = wr && (addr == ADDR_MASK);
  assign flag_set = wr && (addr == ADDR_SWTRIP);
  assign flag_clr = rd && (addr == ADDR_SWTRIP);

  always_comb begin
    status_word = '0;
    status_word[STAT_TRIP_BIT]  = trip_level;
    status_word[STAT_LATCH_BIT] = latch_state;
    mask_word = '0;
    mask_word[N-1:0] = mask_q;
    flag_word = '0;
    flag_word[0] = flag_q;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = wdata[N-1:0];

    flag_d = flag_q;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    rdata_d = '0;
    if (rd) begin
      case (addr)
        ADDR_STATUS: rdata_d = status_word;
        ADDR_MASK:   rdata_d = mask_word;
        ADDR_SWTRIP: rdata_d = flag_word;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign mask     = mask_q;
  assign sw_trip  = flag_set;
  assign reen_req = wr && (addr == ADDR_CTRL) && wdata[CTRL_REEN_BIT];
endmodule

// File: rtl/shutdown_latch.sv
module shutdown_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_sw,
  input  logic set_pin,
  input  logic set_line,
  input  logic fault_active,
  input  logic reen_req,
  output logic latched
);
  logic latch_q, latch_d;
  logic any_set, clear_ok;

  assign any_set  = set_sw | set_pin | set_line;
  assign clear_ok = reen_req & ~fault_active & ~any_set;

  always_comb begin
    latch_d = latch_q;
    if (any_set)       latch_d = 1'b1;
    else if (clear_ok) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b1;
    else        latch_q <= latch_d;
  end

  assign latched = latch_q;
endmodule

// File: rtl/pwm_fault_ctrl.sv
module pwm_fault_ctrl
  import pwm_fault_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trip_n,
  input  logic [NUM_LINES-1:0] gpio_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 sync_in,
  output logic                 sync_out,
  output logic                 sync_irq,
  output logic                 shutdown
);
  localparam int unsigned SYNC_W = NUM_LINES + 1;

  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic [SYNC_W-1:0]    raw_in;
  logic [SYNC_W-1:0]    synced;
  logic                 trip_sync;
  logic [NUM_LINES-1:0] lines_sync;
  logic [NUM_LINES-1:0] mask;
  logic                 line_fall, line_low;
  logic                 sw_trip, reen_req;
  logic                 latched;
  logic                 irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_in = {trip_n, gpio_in};

  fault_sync #(.WIDTH(SYNC_W), .RST_VAL('0)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_in),
    .q     (synced)
  );
  assign trip_sync  = synced[SYNC_W-1];
  assign lines_sync = synced[NUM_LINES-1:0];

  gpio_edge_detect #(.N(NUM_LINES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lines    (lines_sync),
    .enable   (mask),
    .fall_any (line_fall),
    .low_any  (line_low)
  );

  fault_regs #(.N(NUM_LINES), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr          (reg_wr),
    .rd          (reg_rd),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .trip_level  (trip_sync),
    .latch_state (latched),
    .rdata       (reg_rdata),
    .mask        (mask),
    .sw_trip     (sw_trip),
    .reen_req    (reen_req)
  );

  shutdown_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .set_sw       (sw_trip),
    .set_pin      (~trip_sync),
    .set_line     (line_fall),
    .fault_active (~trip_sync | line_low),
    .reen_req     (reen_req),
    .latched      (latched)
  );

  // Asynchronous path: the pin level forces shutdown without a clock.
  assign shutdown = latched | ~trip_n;
  assign sync_out = sync_in & ~shutdown;

  always_comb irq_d = sync_in & ~shutdown;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign sync_irq = irq_q;
endmodule

// File: rtl/pwm_fault_ctrl_checker.sv
module pwm_fault_ctrl_checker
  import pwm_fault_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              trip_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sync_in,
  input logic              sync_out,
  input logic              sync_irq,
  input logic              shutdown
);
  // R1: a low trip pin is always seen as shutdown
  assert_pin_forces_shutdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> shutdown);

  // R6: a software trip write shuts down on the next edge
  assert_sw_write_trips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_SWTRIP) |=> shutdown);

  // R7: two back-to-back reads of the trip register, the second returns 0
  assert_flag_clears_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_SWTRIP) ##1
    (reg_rd && !reg_wr && reg_addr == ADDR_SWTRIP) |=> (reg_rdata == '0));

  // R9: re-enable while the pin is low leaves shutdown asserted
  assert_reen_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CTRL && !trip_n) |=> shutdown);

  // R10: no sync pulse escapes while shut down
  assert_sync_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !sync_out);

  // R10: an interrupt request always follows a sync input pulse
  assert_irq_follows_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_irq) |-> $past(sync_in));

  // R11: read data is zero unless a read happened in the previous cycle
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));

  // R2: status upper bits are always zero
  assert_status_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STATUS) |=> (reg_rdata[DATA_W-1:2] == '0));
endmodule

bind pwm_fault_ctrl pwm_fault_ctrl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trip_n    (trip_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sync_in   (sync_in),
  .sync_out  (sync_out),
  .sync_irq  (sync_irq),
  .shutdown  (shutdown)
);

// File: tb/pwm_fault_ctrl_test.sv
module pwm_fault_ctrl_test;
  localparam int NVEC = 22;

  typedef struct packed {
    logic [11:0] gpio;
    logic        trip;
    logic [1:0]  op;     // 0 none, 1 write, 2 read
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic        exp_sd;
    logic [15:0] exp_rd;
  } vec_t;

  // Addresses: 0 status {latch,trip}, 1 mask, 2 software trip, 3 re-enable (bit 0).
  localparam vec_t VECS [0:NVEC-1] = '{
    '{12'h000, 1'b1, 2'd2, 2'd1, 16'h0000, 1'b1, 16'h0FFF}, // 0  R3 R5 reset mask, shut down
    '{12'h000, 1'b1, 2'd2, 2'd0, 16'h0000, 1'b1, 16'h0003}, // 1  R2 status trip=1 latch=1
    '{12'h000, 1'b1, 2'd1, 2'd3, 16'h0001, 1'b1, 16'h0000}, // 2  R9 blocked: enabled lines low
    '{12'hFFF, 1'b1, 2'd1, 2'd3, 16'h0001, 1'b0, 16'h0000}, // 3  R9 re-enable succeeds
    '{12'hFFF, 1'b1, 2'd2, 2'd0, 16'h0000, 1'b0, 16'h0001}, // 4  R2 latch clear
    '{12'hFFF, 1'b1, 2'd1, 2'd1, 16'h0FF0, 1'b0, 16'h0000}, // 5  R3 disable lines 0..3
    '{12'hFFE, 1'b1, 2'd2, 2'd0, 16'h0000, 1'b0, 16'h0001}, // 6  R4 disabled line 0 falls
    '{12'hEFE, 1'b1, 2'd0, 2'd0, 16'h0000, 1'b1, 16'h0000}, // 7  R4 enabled line 8 falls
    '{12'hEFE, 1'b1, 2'd2, 2'd2, 16'h0000, 1'b1, 16'h0000}, // 8  R8 line trip leaves flag 0
    '{12'hFFE, 1'b1, 2'd1, 2'd3, 16'h0001, 1'b0, 16'h0000}, // 9  R9 re-enable
    '{12'hFFE, 1'b1, 2'd1, 2'd2, 16'h0000, 1'b1, 16'h0000}, // 10 R6 write of zero trips
    '{12'hFFE, 1'b1, 2'd2, 2'd2, 16'h0000, 1'b1, 16'h0001}, // 11 R7 flag reads 1
    '{12'hFFE, 1'b1, 2'd2, 2'd2, 16'h0000, 1'b1, 16'h0000}, // 12 R7 flag cleared
    '{12'hFFE, 1'b1, 2'd1, 2'd3, 16'h0001, 1'b0, 16'h0000}, // 13 R9 re-enable
    '{12'hFFE, 1'b1, 2'd1, 2'd2, 16'hABCD, 1'b1, 16'h0000}, // 14 R6 other value trips
    '{12'hFFE, 1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 16'h0000}, // 15 R1 pin trip
    '{12'hFFE, 1'b0, 2'd2, 2'd2, 16'h0000, 1'b1, 16'h0001}, // 16 R8 pin trip keeps flag
    '{12'hFFE, 1'b0, 2'd1, 2'd3, 16'h0001, 1'b1, 16'h0000}, // 17 R9 blocked by pin
    '{12'hFFE, 1'b0, 2'd2, 2'd0, 16'h0000, 1'b1, 16'h0002}, // 18 R2 trip=0 latch=1
    '{12'hFFE, 1'b1, 2'd1, 2'd3, 16'h0001, 1'b0, 16'h0000}, // 19 R9 re-enable
    '{12'hFFE, 1'b1, 2'd1, 2'd1, 16'hF00F, 1'b0, 16'h0000}, // 20 R3 write wide mask
    '{12'hFFE, 1'b1, 2'd2, 2'd1, 16'h0000, 1'b0, 16'h000F}  // 21 R3 upper bits dropped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trip_n = 1'b1;
  logic [11:0] gpio_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sync_in = 1'b0;
  logic        sync_out, sync_irq, shutdown;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_fault_ctrl uut (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .gpio_in(gpio_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
    .sync_out(sync_out), .sync_irq(sync_irq), .shutdown(shutdown)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    do_reset();
    check("R5 reset shutdown", {15'd0, shutdown}, 16'd1);
    check("R11 idle rdata", reg_rdata, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      gpio_in = VECS[i].gpio;
      trip_n  = VECS[i].trip;
      repeat (4) @(negedge clk);
      if (VECS[i].op == 2'd1) do_write(VECS[i].addr, VECS[i].wdata);
      if (VECS[i].op == 2'd2) begin
        do_read(VECS[i].addr, rd);
        check($sformatf("vector %0d rdata", i), rd, VECS[i].exp_rd);
      end
      repeat (2) @(negedge clk);
      check($sformatf("vector %0d shutdown", i), {15'd0, shutdown}, {15'd0, VECS[i].exp_sd});
    end

    // R10 and R11: running state, sync passes and interrupt follows one cycle later
    @(negedge clk); sync_in = 1'b1; #1;
    check("R10 sync passes", {15'd0, sync_out}, 16'd1);
    check("R11 rdata zero without read", reg_rdata, 16'd0);
    @(negedge clk); sync_in = 1'b0; #1;
    check("R10 irq raised", {15'd0, sync_irq}, 16'd1);
    @(negedge clk); #1;
    check("R10 irq single cycle", {15'd0, sync_irq}, 16'd0);

    // R1: pin low forces shutdown before any clock edge
    @(negedge clk); trip_n = 1'b0; #1;
    check("R1 async shutdown", {15'd0, shutdown}, 16'd1);
    sync_in = 1'b1; #1;
    check("R10 sync blocked", {15'd0, sync_out}, 16'd0);
    @(negedge clk); sync_in = 1'b0; #1;
    check("R10 irq blocked", {15'd0, sync_irq}, 16'd0);
    @(negedge clk); trip_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 latched after pin pulse", {15'd0, shutdown}, 16'd1);

    // R5 and R3: reset in the middle of operation restores defaults
    do_reset();
    check("R5 reset again shutdown", {15'd0, shutdown}, 16'd1);
    do_read(2'd1, rd);
    check("R3 mask default after reset", rd, 16'h0FFF);
    do_read(2'd2, rd);
    check("R7 flag zero after reset", rd, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule